// File: doc/BRIEF.md
# Single-Segment SD Data DMA Engine

This block moves one contiguous, 8-byte aligned buffer between system memory and the SD data path FIFO. Software writes a mode word, a 64-bit start address as two 32-bit halves, and then sets a self-clearing go bit. The engine sizes the transfer from the block size and block count presented by the data path. It then walks the buffer one beat at a time on a simple request/acknowledge memory master, and emits a one-cycle done pulse when the final beat has been handed over.

For memory-to-card transfers, each beat is read from memory and offered on an outbound valid/ready stream. For card-to-memory transfers, each beat is taken from an inbound valid/ready stream and written to memory. Each direction has its own channel-hold bit. Dropping that bit while a transfer runs in that direction abandons the transfer. Raising the bit again re-arms the channel.

Top module: `seg_dma_top`

## Requirements
- R1: After reset no memory request, no stream valid or ready and no done are driven. Register reads return 0 for the mode word, the control word and both address halves, and 0x300 for the channel-hold word (bits 8 and 9 set, both channels released).
- R2: The mode word (register index 0) holds the direction in bits [17:16], the beat-width code in bits [5:4] and the increment flag in bit 0. It reads back exactly these bits. The width code (0, 1, 2, 3 for 1, 2, 4, 8 bytes per beat) appears on `mem_size` for the transfer.
- R3: The start address is the high word (register index 4) above the low word (register index 3). The first beat uses this address.
- R4: A transfer performs exactly (blk_size × blk_count) >> width-code memory handshakes.
- R5: With bit 0 of the mode word set, the address advances by the beat size after every beat. With it clear, every beat uses the start address.
- R6: Direction 0 (memory to card): each beat is a read (`mem_we` = 0). Its data appears on `tx_data` before the next read is issued. A request holds its address until acknowledged, and an offered beat holds its data until accepted.
- R7: Direction 1 (card to memory): each accepted `rx_data` word is written (`mem_we` = 1) with unchanged data, in arrival order.
- R8: `done` is high for exactly one cycle, the cycle after the final beat's handshake. Control bit 0 (register index 1) reads 1 while a transfer runs and 0 once it has ended, without any software clear.
- R9: A go request is ignored when the start address has any of bits [2:0] set, when the transfer length is zero, or when the direction code is 2 or 3.
- R10: A go request while a transfer runs is ignored and does not change the number of beats.
- R11: A go request is ignored while the hold bit for the requested direction is low (bit 8 for direction 0, bit 9 for direction 1, register index 2).
- R12: Clearing the active direction's hold bit mid-transfer leaves all handshake outputs idle from the second rising edge after the write. No done is produced, and control bit 0 reads 0. After the bit is set again, a new transfer runs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| blk_size | input | BSZ_W | Block size in bytes from the data path |
| blk_count | input | CNT_W | Block count from the data path |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 64 | Memory byte address |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| tx_valid | output | 1 | Outbound beat valid (to card FIFO) |
| tx_data | output | DW | Outbound beat data |
| tx_ready | input | 1 | Outbound beat accepted |
| rx_valid | input | 1 | Inbound beat valid (from card FIFO) |
| rx_data | input | DW | Inbound beat data |
| rx_ready | output | 1 | Inbound beat accepted |
| done | output | 1 | One-cycle completion pulse |

## Verification
A register write lands on the rising edge that follows it, so the first memory request or inbound ready of a transfer shows one cycle after the go write. `done` rises one cycle after the edge that completes the final handshake, and an abort empties the outputs one edge later still. The bench drives on falling edges and samples 1 ns after them. It logs every memory and stream handshake in the cycle it occurs, compares counts and beat contents only after the done pulse has been seen, and for ignored go requests waits several cycles before confirming that no handshake was logged.

// File: rtl/seg_dma_pkg.sv
package seg_dma_pkg;
   localparam int unsigned REG_IDX_W = 3;

   localparam logic [REG_IDX_W-1:0] RIX_MODE    = 3'd0;
   localparam logic [REG_IDX_W-1:0] RIX_CTRL    = 3'd1;
   localparam logic [REG_IDX_W-1:0] RIX_CHRST   = 3'd2;
   localparam logic [REG_IDX_W-1:0] RIX_BASE_LO = 3'd3;
   localparam logic [REG_IDX_W-1:0] RIX_BASE_HI = 3'd4;

   localparam int unsigned MODE_DIR_LSB = 16;
   localparam int unsigned MODE_WID_LSB = 4;
   localparam int unsigned MODE_INC_BIT = 0;
   localparam int unsigned CTRL_GO_BIT  = 0;
   localparam int unsigned CHRST_LSB    = 8;
   localparam int unsigned NUM_CH       = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_PUSH,
      ST_PULL,
      ST_STORE
   } seg_state_t;

   typedef struct packed {
      logic [1:0] dir;
      logic [1:0] wid;
      logic       inc;
   } seg_mode_t;
endpackage

// File: rtl/seg_dma_regs.sv
module seg_dma_regs
   import seg_dma_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [REG_IDX_W-1:0] reg_addr,
   input  logic [31:0]          reg_wdata,
   input  logic                 busy,
   output logic [31:0]          reg_rdata,
   output seg_mode_t            mode,
   output logic [63:0]          base_addr,
   output logic [NUM_CH-1:0]    ch_run,
   output logic                 go
);
   seg_mode_t          mode_q;
   logic [31:0]        lo_q;
   logic [31:0]        hi_q;
   logic [NUM_CH-1:0]  run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         run_q  <= '1;
      end else if (reg_we) begin
         case (reg_addr)
            RIX_MODE: begin
               mode_q.dir <= reg_wdata[MODE_DIR_LSB +: 2];
               mode_q.wid <= reg_wdata[MODE_WID_LSB +: 2];
               mode_q.inc <= reg_wdata[MODE_INC_BIT];
            end
            RIX_CHRST:   run_q <= reg_wdata[CHRST_LSB +: NUM_CH];
            RIX_BASE_LO: lo_q  <= reg_wdata;
            RIX_BASE_HI: hi_q  <= reg_wdata;
            default: ;
         endcase
      end
   end

   // go is a strobe only; its readback reflects the running state
   assign go = reg_we && (reg_addr == RIX_CTRL) && reg_wdata[CTRL_GO_BIT];

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RIX_MODE: begin
            reg_rdata[MODE_DIR_LSB +: 2] = mode_q.dir;
            reg_rdata[MODE_WID_LSB +: 2] = mode_q.wid;
            reg_rdata[MODE_INC_BIT]      = mode_q.inc;
         end
         RIX_CTRL:    reg_rdata[CTRL_GO_BIT] = busy;
         RIX_CHRST:   reg_rdata[CHRST_LSB +: NUM_CH] = run_q;
         RIX_BASE_LO: reg_rdata = lo_q;
         RIX_BASE_HI: reg_rdata = hi_q;
         default:     reg_rdata = '0;
      endcase
   end

   assign mode      = mode_q;
   assign base_addr = {hi_q, lo_q};
   assign ch_run    = run_q;
endmodule

// File: rtl/seg_dma_len.sv
module seg_dma_len #(
   parameter int unsigned BSZ_W = 12,
   parameter int unsigned CNT_W = 16,
   localparam int unsigned LEN_W = BSZ_W + CNT_W
) (
   input  logic [BSZ_W-1:0] blk_size,
   input  logic [CNT_W-1:0] blk_count,
   input  logic [1:0]       wid,
   output logic [LEN_W-1:0] beats,
   output logic             empty
);
   logic [LEN_W-1:0] total_bytes;

   assign total_bytes = LEN_W'(blk_size) * LEN_W'(blk_count);
   assign beats       = total_bytes >> wid;
   assign empty       = (beats == '0);
endmodule

// File: rtl/seg_dma_addr.sv
module seg_dma_addr #(
   parameter int unsigned AW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          inc,
   input  logic [1:0]    wid,
   input  logic          adv,
   output logic [AW-1:0] cur,
   output logic [1:0]    size
);
   logic [AW-1:0] cur_q;
   logic [AW-1:0] step_q;
   logic [1:0]    wid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         step_q <= '0;
         wid_q  <= '0;
      end else if (load) begin
         cur_q  <= base;
         step_q <= inc ? (AW'(1) << wid) : '0;
         wid_q  <= wid;
      end else if (adv) begin
         cur_q  <= cur_q + step_q;
      end
   end

   assign cur  = cur_q;
   assign size = wid_q;
endmodule

// File: rtl/seg_dma_seq.sv
module seg_dma_seq
   import seg_dma_pkg::*;
#(
   parameter int unsigned DW    = 64,
   parameter int unsigned LEN_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dir_in,
   input  logic [LEN_W-1:0] beats_in,
   input  logic             abort,
   input  logic             mem_ack,
   input  logic [DW-1:0]    mem_rdata,
   input  logic             tx_ready,
   input  logic             rx_valid,
   input  logic [DW-1:0]    rx_data,
   output logic             busy,
   output logic             act_dir,
   output logic             adv,
   output logic             mem_req,
   output logic             mem_we,
   output logic [DW-1:0]    mem_wdata,
   output logic             tx_valid,
   output logic [DW-1:0]    tx_data,
   output logic             rx_ready,
   output logic             done
);
   seg_state_t       state_q, state_d;
   logic [LEN_W-1:0] left_q, left_d;
   logic [DW-1:0]    hold_q, hold_d;
   logic             dir_q, dir_d;
   logic             done_q, done_d;
   logic             beat_fin;

   always_comb begin
      state_d  = state_q;
      left_d   = left_q;
      hold_d   = hold_q;
      dir_d    = dir_q;
      done_d   = 1'b0;
      beat_fin = 1'b0;
      adv      = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               dir_d   = dir_in;
               left_d  = beats_in;
               state_d = dir_in ? ST_PULL : ST_FETCH;
            end
         end
         ST_FETCH: begin
            if (mem_ack) begin
               hold_d  = mem_rdata;
               state_d = ST_PUSH;
            end
         end
         ST_PUSH:  beat_fin = tx_ready;
         ST_PULL: begin
            if (rx_valid) begin
               hold_d  = rx_data;
               state_d = ST_STORE;
            end
         end
         ST_STORE: beat_fin = mem_ack;
         default:  state_d = ST_IDLE;
      endcase

      if (beat_fin) begin
         adv    = 1'b1;
         left_d = left_q - LEN_W'(1);
         if (left_q == LEN_W'(1)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
         end else begin
            state_d = dir_q ? ST_PULL : ST_FETCH;
         end
      end

      if (abort) begin
         state_d = ST_IDLE;
         done_d  = 1'b0;
         adv     = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         hold_q  <= '0;
         dir_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         left_q  <= left_d;
         hold_q  <= hold_d;
         dir_q   <= dir_d;
         done_q  <= done_d;
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign act_dir   = dir_q;
   assign mem_req   = (state_q == ST_FETCH) || (state_q == ST_STORE);
   assign mem_we    = (state_q == ST_STORE);
   assign mem_wdata = hold_q;
   assign tx_valid  = (state_q == ST_PUSH);
   assign tx_data   = hold_q;
   assign rx_ready  = (state_q == ST_PULL);
   assign done      = done_q;
endmodule

// File: rtl/seg_dma_top.sv
module seg_dma_top
   import seg_dma_pkg::*;
#(
   parameter int unsigned DW          = 64,
   parameter int unsigned BSZ_W       = 12,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned ALIGN_BYTES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [REG_IDX_W-1:0] reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [BSZ_W-1:0]     blk_size,
   input  logic [CNT_W-1:0]     blk_count,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [63:0]          mem_addr,
   output logic [1:0]           mem_size,
   output logic [DW-1:0]        mem_wdata,
   input  logic [DW-1:0]        mem_rdata,
   input  logic                 mem_ack,
   output logic                 tx_valid,
   output logic [DW-1:0]        tx_data,
   input  logic                 tx_ready,
   input  logic                 rx_valid,
   input  logic [DW-1:0]        rx_data,
   output logic                 rx_ready,
   output logic                 done
);
   localparam int unsigned LEN_W     = BSZ_W + CNT_W;
   localparam int unsigned ALIGN_LSB = $clog2(ALIGN_BYTES);

   if (DW != 64) begin : g_bad_dw
      $error("seg_dma_top: beat data path must be 64 bits wide");
   end
   if (ALIGN_LSB == 0 || ALIGN_BYTES != (1 << ALIGN_LSB)) begin : g_bad_align
      $error("seg_dma_top: ALIGN_BYTES must be a power of two above 1");
   end
   if (BSZ_W < 4 || CNT_W < 1) begin : g_bad_len
      $error("seg_dma_top: block size or count field too narrow");
   end

   seg_mode_t          mode;
   logic [63:0]        base_addr;
   logic [NUM_CH-1:0]  ch_run;
   logic               go;
   logic               busy;
   logic               act_dir;
   logic               adv;
   logic [LEN_W-1:0]   beats;
   logic               len_empty;
   logic               accept;
   logic               abort;
   logic [NUM_CH-1:0]  ch_kill;

   seg_dma_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .busy      (busy),
      .reg_rdata (reg_rdata),
      .mode      (mode),
      .base_addr (base_addr),
      .ch_run    (ch_run),
      .go        (go)
   );

   seg_dma_len #(.BSZ_W(BSZ_W), .CNT_W(CNT_W)) u_len (
      .blk_size  (blk_size),
      .blk_count (blk_count),
      .wid       (mode.wid),
      .beats     (beats),
      .empty     (len_empty)
   );

   // a go is taken only when idle, for a defined direction whose channel
   // is released, on an aligned base and a non-empty length
   assign accept = go && !busy && (mode.dir[1] == 1'b0) && ch_run[mode.dir[0]]
                   && (base_addr[ALIGN_LSB-1:0] == '0) && !len_empty;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ch_kill[c] = busy && !ch_run[c] && (int'(act_dir) == c);
   end
   assign abort = |ch_kill;

   seg_dma_addr #(.AW(64)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .base  (base_addr),
      .inc   (mode.inc),
      .wid   (mode.wid),
      .adv   (adv),
      .cur   (mem_addr),
      .size  (mem_size)
   );

   seg_dma_seq #(.DW(DW), .LEN_W(LEN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .dir_in    (mode.dir[0]),
      .beats_in  (beats),
      .abort     (abort),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .tx_ready  (tx_ready),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .busy      (busy),
      .act_dir   (act_dir),
      .adv       (adv),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .rx_ready  (rx_ready),
      .done      (done)
   );
endmodule

// File: rtl/seg_dma_chk.sv
module seg_dma_chk #(
   parameter int unsigned DW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ack,
   input logic [63:0]   mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          tx_valid,
   input logic          tx_ready,
   input logic [DW-1:0] tx_data,
   input logic          rx_valid,
   input logic          rx_ready,
   input logic [DW-1:0] rx_data,
   input logic          done,
   input logic          busy,
   input logic          kill
);
   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack && !kill |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R6
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !kill |=> tx_valid && $stable(tx_data));

   // R7
   store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_ready && !kill |=> mem_req && mem_we && (mem_wdata == $past(rx_data)));

   // R6
   one_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, tx_valid, rx_ready}));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past((mem_req && mem_ack) || (tx_valid && tx_ready)) && !busy);

   // R12
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !busy && !mem_req && !tx_valid && !rx_ready && !done);
endmodule

bind seg_dma_top seg_dma_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_data   (tx_data),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .rx_data   (rx_data),
   .done      (done),
   .busy      (busy),
   .kill      (abort)
);

// File: tb/seg_dma_top_tb.sv
module seg_dma_top_tb;
   import seg_dma_pkg::*;

   localparam int BSZ_W = 12;
   localparam int CNT_W = 16;
   localparam int DW    = 64;
   localparam int NV    = 6;
   localparam logic [63:0] RD_KEY = 64'hC3A5_0F1E_9B2D_7860;

   // {dir, wid, inc, blk_size, blk_count, addr_lo, addr_hi, expected beats}
   localparam logic [103:0] VEC [NV] = '{
      {1'b0, 2'd3, 1'b1, 12'd16, 16'd2, 32'h0000_1000, 32'h0000_0000, 8'd4},
      {1'b1, 2'd3, 1'b1, 12'd8,  16'd3, 32'h0000_2000, 32'h0000_0001, 8'd3},
      {1'b0, 2'd2, 1'b1, 12'd8,  16'd1, 32'h0000_3000, 32'h0000_0000, 8'd2},
      {1'b1, 2'd0, 1'b1, 12'd4,  16'd1, 32'h0000_4008, 32'h8000_0000, 8'd4},
      {1'b0, 2'd3, 1'b0, 12'd24, 16'd1, 32'h0000_5000, 32'h0000_0000, 8'd3},
      {1'b1, 2'd1, 1'b0, 12'd8,  16'd1, 32'h0000_6000, 32'h0000_0002, 8'd4}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 reg_we = 1'b0;
   logic [REG_IDX_W-1:0] reg_addr = '0;
   logic [31:0]          reg_wdata = '0;
   logic [31:0]          reg_rdata;
   logic [BSZ_W-1:0]     blk_size = '0;
   logic [CNT_W-1:0]     blk_count = '0;
   logic                 mem_req, mem_we, mem_ack;
   logic [63:0]          mem_addr;
   logic [1:0]           mem_size;
   logic [DW-1:0]        mem_wdata, mem_rdata;
   logic                 tx_valid, tx_ready;
   logic [DW-1:0]        tx_data;
   logic                 rx_valid, rx_ready;
   logic [DW-1:0]        rx_data;
   logic                 done;

   logic ack_en = 1'b1, tx_en = 1'b1, rx_en = 1'b1, stall = 1'b0, ph = 1'b0;
   logic [63:0] rx_seq = 64'h100;
   logic        rx_pend = 1'b0;
   logic [63:0] log_addr [64];
   logic [63:0] log_data [64];
   logic        log_we   [64];
   logic [63:0] tx_log   [64];
   int n_log = 0, n_tx = 0, n_done = 0;
   int n_chk = 0, n_bad = 0;
   logic finished = 1'b0;

   always #4 clk = ~clk;

   assign mem_ack   = mem_req & ack_en & (ph | ~stall);
   assign mem_rdata = mem_addr ^ RD_KEY;
   assign tx_ready  = tx_en & (ph | ~stall);
   assign rx_valid  = rx_en & (ph | ~stall);
   assign rx_data   = rx_seq;

   seg_dma_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_size(blk_size),
      .blk_count(blk_count), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_ready(rx_ready), .done(done)
   );

   // handshake monitor: drives change at the falling edge, sampling 1 ns later
   always @(negedge clk) begin
      ph = ~ph;
      if (rx_pend) begin
         rx_seq  = rx_seq + 64'd1;
         rx_pend = 1'b0;
      end
      #1;
      if (rst_n) begin
         if (mem_req && mem_ack) begin
            if (n_log < 64) begin
               log_addr[n_log] = mem_addr;
               log_we[n_log]   = mem_we;
               log_data[n_log] = mem_we ? mem_wdata : mem_rdata;
            end
            n_log++;
         end
         if (tx_valid && tx_ready) begin
            if (n_tx < 64) tx_log[n_tx] = tx_data;
            n_tx++;
         end
         if (rx_valid && rx_ready) rx_pend = 1'b1;
         if (done) n_done++;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [REG_IDX_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [REG_IDX_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #2;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_logs();
      n_log = 0; n_tx = 0; n_done = 0;
   endtask

   task automatic wait_done(input int lim);
      for (int i = 0; i < lim; i++) begin
         @(negedge clk); #2;
         if (n_done > 0) break;
      end
   endtask

   function automatic logic [31:0] mw(input logic [1:0] dir, input logic [1:0] wid, input logic inc);
      return (32'(dir) << MODE_DIR_LSB) | (32'(wid) << MODE_WID_LSB) | 32'(inc);
   endfunction

   initial begin
      logic [31:0] r;
      rd(RIX_MODE, r);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      #2;
      chk("R1 mem_req", 64'(mem_req), 0);
      chk("R1 tx_valid", 64'(tx_valid), 0);
      chk("R1 rx_ready", 64'(rx_ready), 0);
      chk("R1 done", 64'(done), 0);
      rd(RIX_MODE, r);    chk("R1 mode", 64'(r), 0);
      rd(RIX_CTRL, r);    chk("R1 ctrl", 64'(r), 0);
      rd(RIX_CHRST, r);   chk("R1 chrst", 64'(r), 64'h300);
      rd(RIX_BASE_LO, r); chk("R1 lo", 64'(r), 0);
      rd(RIX_BASE_HI, r); chk("R1 hi", 64'(r), 0);

      // table of transfers
      for (int v = 0; v < NV; v++) begin
         logic        dir;
         logic [1:0]  wid;
         logic        inc;
         logic [63:0] base, step, rx_base;
         int          nexp;
         dir  = VEC[v][103];
         wid  = VEC[v][102:101];
         inc  = VEC[v][100];
         blk_size  = VEC[v][99:88];
         blk_count = VEC[v][87:72];
         base = {VEC[v][39:8], VEC[v][71:40]};
         nexp = int'(VEC[v][7:0]);
         step = inc ? (64'd1 << wid) : 64'd0;
         stall = v[0];
         wr(RIX_MODE, mw({1'b0, dir}, wid, inc));
         rd(RIX_MODE, r);
         chk("R2 mode readback", 64'(r), 64'(mw({1'b0, dir}, wid, inc)));
         wr(RIX_BASE_LO, base[31:0]);
         wr(RIX_BASE_HI, base[63:32]);
         clear_logs();
         rx_base = rx_seq;
         wr(RIX_CTRL, 32'h1);
         rd(RIX_CTRL, r);
         chk("R8 running flag", 64'(r[0]), 1);
         wait_done(400);
         chk("R8 done count", 64'(n_done), 1);
         chk("R4 beat count", 64'(n_log), 64'(nexp));
         chk("R2 mem_size", 64'(mem_size), 64'(wid));
         for (int k = 0; k < nexp && k < n_log; k++) begin
            chk(inc ? "R5 R3 inc addr" : "R5 R3 fixed addr", log_addr[k], base + step * 64'(k));
            if (!dir) begin
               chk("R6 read kind", 64'(log_we[k]), 0);
               chk("R6 tx data", tx_log[k], (base + step * 64'(k)) ^ RD_KEY);
            end else begin
               chk("R7 write kind", 64'(log_we[k]), 1);
               chk("R7 write data", log_data[k], rx_base + 64'(k));
            end
         end
         if (!dir) chk("R6 tx count", 64'(n_tx), 64'(nexp));
         rd(RIX_CTRL, r);
         chk("R8 self clear", 64'(r[0]), 0);
         stall = 1'b0;
      end

      // R9 misaligned base
      blk_size = 12'd8; blk_count = 16'd2;
      wr(RIX_MODE, mw(2'd0, 2'd3, 1'b1));
      wr(RIX_BASE_HI, 32'h0);
      wr(RIX_BASE_LO, 32'h0000_7004);
      clear_logs();
      wr(RIX_CTRL, 32'h1);
      idle(8);
      chk("R9 misaligned ignored", 64'(n_log + n_done), 0);
      rd(RIX_CTRL, r); chk("R9 misaligned idle", 64'(r), 0);

      // R9 zero length
      wr(RIX_BASE_LO, 32'h0000_7000);
      blk_count = 16'd0;
      clear_logs();
      wr(RIX_CTRL, 32'h1);
      idle(8);
      chk("R9 zero length ignored", 64'(n_log + n_done), 0);

      // R9 undefined direction
      blk_count = 16'd2;
      wr(RIX_MODE, mw(2'd2, 2'd3, 1'b1));
      clear_logs();
      wr(RIX_CTRL, 32'h1);
      idle(8);
      chk("R9 bad direction ignored", 64'(n_log + n_done + 32'(rx_ready)), 0);

      // R11 channel held in reset
      wr(RIX_CHRST, 32'h200);
      wr(RIX_MODE, mw(2'd0, 2'd3, 1'b1));
      clear_logs();
      wr(RIX_CTRL, 32'h1);
      idle(8);
      chk("R11 ch0 held ignored", 64'(n_log + n_done), 0);
      wr(RIX_CHRST, 32'h100);
      wr(RIX_MODE, mw(2'd1, 2'd3, 1'b1));
      clear_logs();
      wr(RIX_CTRL, 32'h1);
      idle(8);
      chk("R11 ch1 held ignored", 64'(n_log + n_done + 32'(rx_ready)), 0);
      wr(RIX_CHRST, 32'h300);

      // R10 go while running
      rx_en = 1'b0;
      blk_size = 12'd8; blk_count = 16'd4;
      clear_logs();
      wr(RIX_CTRL, 32'h1);
      idle(3);
      wr(RIX_CTRL, 32'h1);
      idle(2);
      rx_en = 1'b1;
      wait_done(200);
      idle(20);
      chk("R10 beats unchanged", 64'(n_log), 4);
      chk("R10 single done", 64'(n_done), 1);

      // R12 abort mid-transfer
      tx_en = 1'b0;
      blk_size = 12'd64; blk_count = 16'd4;
      wr(RIX_MODE, mw(2'd0, 2'd3, 1'b1));
      clear_logs();
      wr(RIX_CTRL, 32'h1);
      idle(5);
      chk("R12 stalled offer", 64'(tx_valid), 1);
      wr(RIX_CHRST, 32'h200);
      @(negedge clk); #2;
      chk("R12 outputs idle", 64'({mem_req, tx_valid, rx_ready}), 0);
      rd(RIX_CTRL, r); chk("R12 flag cleared", 64'(r), 0);
      tx_en = 1'b1;
      idle(10);
      chk("R12 no done", 64'(n_done + n_tx), 0);
      wr(RIX_CHRST, 32'h300);
      blk_size = 12'd8; blk_count = 16'd1;
      clear_logs();
      wr(RIX_CTRL, 32'h1);
      wait_done(100);
      chk("R12 rearmed transfer", 64'(n_done * 100 + n_tx), 101);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule